// File: doc/BRIEF.md
# ISA I/O Command Recovery Timer

This block keeps back-to-back ISA I/O commands apart. It watches the active-low read and write command strobes. When a strobe returns high, which ends a command, it starts a recovery interval. While that interval runs, it holds back the grant for any following 8-bit or 16-bit I/O cycle. The interval is counted in half periods of the bus clock. The caller supplies these as a one-cycle `half_tick` pulse for each half period, so the half-clock part of the 3.5-clock minimum is timed exactly.

A requester raises `start_req` and describes its cycle with `start_io` and `start_sub`, holding them until `start_gnt` rises. Memory cycles are not delayed by the interval. Sub-cycles produced when a wide access is split into bytes are not delayed either. The `rcv_extra` setting adds whole bus clocks to the fixed minimum. A request that arrives while an interval is running is held, not dropped. It is granted in the cycle in which the interval expires.

Top module: `iorec_timer`

## Requirements
- R1: A synchronous active-high `rst` clears the recovery count and `start_gnt`. With no command ended since reset, an I/O request is granted on the first clock edge that samples it.
- R2: A command ends on the first clock edge that samples both `cmd_rd_n` and `cmd_wr_n` high after an edge that sampled either of them low. After that edge, a non-sub-cycle I/O request is not granted until 7 + 2*`rcv_extra` `half_tick` pulses have been sampled on later edges.
- R3: The grant for a held I/O request rises on the very clock edge that samples the last `half_tick` pulse of the interval, so `start_gnt` is registered and adds no cycle.
- R4: `rcv_extra` is taken only on the edge where a command ends. Changing it while an interval runs does not alter that interval's length.
- R5: A request with `start_io` low (memory cycle) is granted on the next edge, even while an interval is running.
- R6: A request with `start_io` and `start_sub` both high (byte sub-cycle) is granted on the next edge, even while an interval is running.
- R7: `start_gnt` is high only after an edge that sampled `start_req` high and both strobes high. It falls on the edge that samples `start_req` low.
- R8: Every command end restarts the interval from its full length, including the end of a sub-cycle command and an end that occurs while an earlier interval is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| half_tick | input | 1 | One-cycle pulse per bus-clock half period |
| cmd_rd_n | input | 1 | I/O read command strobe, active low |
| cmd_wr_n | input | 1 | I/O write command strobe, active low |
| start_req | input | 1 | Request to start a bus cycle, held until granted |
| start_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| start_sub | input | 1 | 1 = byte assembly/disassembly sub-cycle |
| rcv_extra | input | EXTRA_W | Extra recovery in whole bus clocks |
| start_gnt | output | 1 | Registered grant for the requested cycle |

## Verification
The hardest case to reach is a command that ends while an earlier recovery interval still has pulses left. That end must reload the count to its full length, not add to the remaining count or leave it alone. The bench reaches this case with an I/O request held through the start of one interval. It then pulses a sub-cycle command a few clocks later, and counts `half_tick` pulses from that second end to predict the grant edge. A second scenario rewrites `rcv_extra` in the middle of an interval. This shows that the length was fixed when the interval started.

// File: rtl/iorec_pkg.sv
package iorec_pkg;
  // Fixed recovery floor: 3.5 bus clocks expressed in half periods
  localparam int FLOOR_HALVES = 7;

  function automatic int rcv_halves(input int extra_clks);
    return FLOOR_HALVES + 2 * extra_clks;
  endfunction
endpackage

// File: rtl/iorec_strobe_mon.sv
module iorec_strobe_mon (
  input  logic clk,
  input  logic rst,
  input  logic rd_n,
  input  logic wr_n,
  output logic busy,
  output logic cmd_done
);
  logic busy_q;

  assign busy = ~rd_n | ~wr_n;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy;
  end

  // Trailing (rising) edge of whichever command strobe was active
  assign cmd_done = busy_q & ~busy;
endmodule

// File: rtl/iorec_counter.sv
module iorec_counter #(
  parameter int EXTRA_W = 4,
  parameter int CNT_W   = EXTRA_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [EXTRA_W-1:0] extra,
  input  logic               tick,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W-1:0]   cnt_nxt
);
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(iorec_pkg::FLOOR_HALVES) + {{(CNT_W-EXTRA_W-1){1'b0}}, extra, 1'b0};

  always_comb begin
    if (load)                          cnt_nxt = load_val;
    else if (tick && cnt_q != '0)      cnt_nxt = cnt_q - CNT_W'(1);
    else                               cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/iorec_timer.sv
module iorec_timer #(
  parameter int EXTRA_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               half_tick,
  input  logic               cmd_rd_n,
  input  logic               cmd_wr_n,
  input  logic               start_req,
  input  logic               start_io,
  input  logic               start_sub,
  input  logic [EXTRA_W-1:0] rcv_extra,
  output logic               start_gnt
);
  localparam int CNT_W = EXTRA_W + 3;

  logic             bus_busy;
  logic             cmd_done;
  logic [CNT_W-1:0] rcv_cnt;
  logic [CNT_W-1:0] rcv_cnt_nxt;
  logic             exempt;
  logic             eligible;

  iorec_strobe_mon u_mon (
    .clk      (clk),
    .rst      (rst),
    .rd_n     (cmd_rd_n),
    .wr_n     (cmd_wr_n),
    .busy     (bus_busy),
    .cmd_done (cmd_done)
  );

  iorec_counter #(.EXTRA_W(EXTRA_W), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (cmd_done),
    .extra   (rcv_extra),
    .tick    (half_tick),
    .cnt_q   (rcv_cnt),
    .cnt_nxt (rcv_cnt_nxt)
  );

  // Memory cycles and byte sub-cycles bypass recovery
  assign exempt   = ~start_io | start_sub;
  assign eligible = exempt | (rcv_cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) start_gnt <= 1'b0;
    else     start_gnt <= start_req & ~bus_busy & eligible;
  end
endmodule

// File: rtl/iorec_timer_chk.sv
module iorec_timer_chk #(
  parameter int EXTRA_W = 4,
  parameter int CNT_W   = EXTRA_W + 3
) (
  input logic               clk,
  input logic               rst,
  input logic               half_tick,
  input logic               cmd_rd_n,
  input logic               cmd_wr_n,
  input logic               start_req,
  input logic               start_io,
  input logic               start_sub,
  input logic [EXTRA_W-1:0] rcv_extra,
  input logic               start_gnt,
  input logic               cmd_done,
  input logic [CNT_W-1:0]   rcv_cnt
);
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (rcv_cnt == '0) && !start_gnt);

  a_r2_io_held_in_recovery: assert property (@(posedge clk) disable iff (rst)
    (start_gnt && $past(start_io) && !$past(start_sub)) |-> (rcv_cnt == '0));

  a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
    (!cmd_done && half_tick && rcv_cnt != '0) |=> (rcv_cnt == $past(rcv_cnt) - CNT_W'(1)));

  a_r8_full_reload: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> (int'(rcv_cnt) == 7 + 2 * int'($past(rcv_extra))));

  a_r7_grant_needs_idle_req: assert property (@(posedge clk) disable iff (rst)
    start_gnt |-> $past(start_req) && $past(cmd_rd_n) && $past(cmd_wr_n));
endmodule

bind iorec_timer iorec_timer_chk #(.EXTRA_W(EXTRA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .half_tick (half_tick),
  .cmd_rd_n  (cmd_rd_n),
  .cmd_wr_n  (cmd_wr_n),
  .start_req (start_req),
  .start_io  (start_io),
  .start_sub (start_sub),
  .rcv_extra (rcv_extra),
  .start_gnt (start_gnt),
  .cmd_done  (cmd_done),
  .rcv_cnt   (rcv_cnt)
);

// File: tb/iorec_timer_tb.sv
`timescale 1ns/1ps
module iorec_timer_tb;
  localparam int EXTRA_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic half_tick = 1'b0;
  logic cmd_rd_n = 1'b1;
  logic cmd_wr_n = 1'b1;
  logic start_req = 1'b0;
  logic start_io = 1'b0;
  logic start_sub = 1'b0;
  logic [EXTRA_W-1:0] rcv_extra = '0;
  logic start_gnt;

  int n_chk = 0;
  int n_bad = 0;
  int hcount = 0;
  int div = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iorec_timer #(.EXTRA_W(EXTRA_W)) u_dut (
    .clk(clk), .rst(rst), .half_tick(half_tick),
    .cmd_rd_n(cmd_rd_n), .cmd_wr_n(cmd_wr_n),
    .start_req(start_req), .start_io(start_io), .start_sub(start_sub),
    .rcv_extra(rcv_extra), .start_gnt(start_gnt)
  );

  // Half-period tick every third core clock
  always @(negedge clk) begin
    div = (div == 2) ? 0 : div + 1;
    half_tick <= (div == 0);
  end

  always @(posedge clk) if (half_tick) hcount <= hcount + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // Run one command: strobe low for one cycle then high again
  task automatic pulse_cmd(input bit use_rd);
    @(negedge clk);
    if (use_rd) cmd_rd_n = 1'b0; else cmd_wr_n = 1'b0;
    @(negedge clk);
    cmd_rd_n = 1'b1;
    cmd_wr_n = 1'b1;
  endtask

  // Caller has just released the strobe; follow the held request to its grant
  task automatic follow_grant(input int halves, input string rq, input int chg_at, input int new_extra);
    int hstart = 0;
    bit exp = 1'b0;
    for (int i = 0; i < 3 * halves + 12; i++) begin
      @(negedge clk);
      if (i == 0) hstart = hcount;
      if (i == chg_at) rcv_extra = EXTRA_W'(new_extra);
      exp = (hcount - hstart) >= halves;
      chk(start_gnt == exp, rq, int'(start_gnt), int'(exp));
      if (exp) break;
    end
    start_req = 1'b0;
    @(negedge clk);
    chk(start_gnt == 1'b0, "R7", int'(start_gnt), 0);
  endtask

  task automatic t_reset;
    chk(start_gnt == 1'b0, "R1", int'(start_gnt), 0);
    start_req = 1'b1; start_io = 1'b1; start_sub = 1'b0;
    @(negedge clk);
    chk(start_gnt == 1'b1, "R1", int'(start_gnt), 1);
    start_req = 1'b0;
    @(negedge clk);
    chk(start_gnt == 1'b0, "R7", int'(start_gnt), 0);
  endtask

  task automatic t_floor_and_extra(input int ex, input bit use_rd);
    rcv_extra = EXTRA_W'(ex);
    pulse_cmd(use_rd);
    start_req = 1'b1; start_io = 1'b1; start_sub = 1'b0;
    follow_grant(7 + 2 * ex, (ex == 0) ? "R2" : "R3", -1, 0);
  endtask

  task automatic t_extra_change;
    rcv_extra = 4'd2;
    pulse_cmd(1'b0);
    start_req = 1'b1; start_io = 1'b1; start_sub = 1'b0;
    follow_grant(11, "R4", 3, 9);
    rcv_extra = '0;
  endtask

  task automatic t_exempt(input bit io, input bit sub, input string rq);
    rcv_extra = 4'd5;
    pulse_cmd(1'b1);
    start_req = 1'b1; start_io = io; start_sub = sub;
    @(negedge clk);
    chk(start_gnt == 1'b1, rq, int'(start_gnt), 1);
    start_req = 1'b0;
    @(negedge clk);
    chk(start_gnt == 1'b0, "R7", int'(start_gnt), 0);
    // let the interval drain before the next scenario
    repeat (60) @(negedge clk);
    start_io = 1'b0; start_sub = 1'b0;
  endtask

  task automatic t_busy_blocks;
    @(negedge clk);
    cmd_wr_n = 1'b0;
    start_req = 1'b1; start_io = 1'b0;
    @(negedge clk);
    chk(start_gnt == 1'b0, "R7", int'(start_gnt), 0);
    @(negedge clk);
    chk(start_gnt == 1'b0, "R7", int'(start_gnt), 0);
    start_req = 1'b0;
    cmd_wr_n = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reload;
    rcv_extra = 4'd1;
    pulse_cmd(1'b1);
    start_req = 1'b1; start_io = 1'b1; start_sub = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(start_gnt == 1'b0, "R8", int'(start_gnt), 0);
    end
    start_req = 1'b0;
    // sub-cycle command ends mid-interval and restarts it
    pulse_cmd(1'b0);
    start_req = 1'b1; start_io = 1'b1; start_sub = 1'b0;
    follow_grant(9, "R8", -1, 0);
    rcv_extra = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_floor_and_extra(0, 1'b1);
    t_floor_and_extra(3, 1'b0);
    t_floor_and_extra(15, 1'b1);
    t_extra_change();
    t_exempt(1'b0, 1'b0, "R5");
    t_exempt(1'b1, 1'b1, "R6");
    t_busy_blocks();
    t_reload();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule